// File: doc/BRIEF.md
# Prescaled Shared 64-bit Count Register Block

This block keeps one 64-bit up-counter that several processor cores share. While the shared run bit is set, the counter steps by one every (ratio + 1) clock cycles. The ratio comes from an 8-bit field of the control word. The current count and the run state go straight out to the per-core comparator channels, which sit outside this block.

Software reaches the block through a 32-bit word bus. The counter shows as a low and a high word. Reading the low word also captures the upper half, so a later read of the high word returns the matching half of the same 64-bit value.

The control word holds bits shared by all cores, plus a small group of bits kept separately for each core. This block stores the shared bits. On a control write, it sends the per-core bits to the requesting core's channel through a one-hot write strobe. On a control read, it merges the shared bits with that core's per-core bits.

Top module: `shared_count64`

## Requirements
- R1: After reset the count is zero, the run output is low, and a control read with all per-core inputs at zero returns zero.
- R2: While control bit 0 (run) is set and the ratio field, control bits 15:8, holds p, the count rises by exactly one every p+1 cycles, and never by more than one per cycle.
- R3: While control bit 0 is clear, the count holds its value.
- R4: A read of byte offset 0x00 returns count bits 31:0 and captures count bits 63:32. A read of offset 0x04 returns the most recently captured upper half, not the live value.
- R5: A write to offset 0x00 or 0x04 replaces count bits 31:0 or 63:32 respectively when control bit 0 is clear, and has no effect while it is set.
- R6: A write to offset 0x08 stores every bit except 3:1 as shared control. In the same cycle it drives bank_wdata_o with written bits 3:1 and raises only the bank_we_o bit selected by core_i.
- R7: A read of offset 0x08 returns the shared control bits ORed with the requesting core's three per-core bits, placed at bits 3:1.
- R8: A control write that changes the ratio field restarts the cycle divider, so the next step comes p+1 cycles after that write with the new p.
- R9: Only accesses with all four byte enables set and a word-aligned offset that targets 0x00, 0x04 or 0x08 act. Any other access returns zero on a read and changes nothing on a write, including no bank_we_o strobe.
- R10: Every read request, accepted or not, gives exactly one rvalid_o pulse with its data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; only 4'hF acts |
| addr_i | input | 5 | Byte offset inside the 0x20 window |
| wdata_i | input | 32 | Write data |
| core_i | input | CORE_W | Index of the requesting core |
| bank_ctrl_i | input | 3*NCORES | Per-core control bits, core c at [3c+2:3c] |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bank_we_o | output | NCORES | One-hot strobe that writes per-core control bits |
| bank_wdata_o | output | 3 | Per-core control bits being written |
| count_o | output | 64 | Live count value |
| enable_o | output | 1 | Shared run bit |

## Verification
Read data is due one cycle after the request. The bank strobe and its data are due in the same cycle as the write. The count reflects a run or ratio change at the clock edge that takes the control write, with its first step p+1 edges later.

The bench pushes each expected read word into a queue when it presents the request. It pops that word only at the falling edge where rvalid_o is high. An early, late, missing or extra pulse therefore shows up as a mismatch or a leftover entry.

The count is checked against a model that counts clock edges from each run or ratio change. The bench samples it on falling edges, after the rising edge that moved it has settled.

// File: rtl/shared_count64_pkg.sv
package shared_count64_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 2 * WORD_W;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BE_W   = WORD_W / 8;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;

  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned BANK_LSB = 1;
  localparam int unsigned BANK_W   = 3;
  localparam int unsigned RATIO_LSB = 8;
  localparam int unsigned RATIO_W   = 8;

  localparam logic [WORD_W-1:0] BANK_MASK = {{(WORD_W-BANK_W-BANK_LSB){1'b0}}, {BANK_W{1'b1}}, {BANK_LSB{1'b0}}};

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
  parameter int unsigned RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               restart_i,
  output logic               tick_o
);
  logic [RATIO_W-1:0] div_q;

  assign tick_o = run_i && (div_q == ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (!run_i || restart_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_counter.sv
module sc_counter #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 2,
  localparam int unsigned CNT_W = WORD_W * NWORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NWORDS-1:0] ld_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_ld;

  // per-word load mux
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign cnt_ld[w*WORD_W +: WORD_W] = ld_i[w] ? wdata_i : cnt_q[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (|ld_i) begin
      cnt_q <= cnt_ld;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sc_regif.sv
module sc_regif
  import shared_count64_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned CORE_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [BE_W-1:0]          be_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic [CORE_W-1:0]        core_i,
  input  logic [NCORES*BANK_W-1:0] bank_ctrl_i,
  input  logic [CNT_W-1:0]         count_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic [WORD_W-1:0]        ctrl_o,
  output logic [1:0]               ld_o,
  output logic                     ratio_chg_o,
  output logic [NCORES-1:0]        bank_we_o,
  output logic [BANK_W-1:0]        bank_wdata_o
);
  logic [WORD_W-1:0]       ctrl_q;
  logic [CNT_W-WORD_W-1:0] snap_q;
  logic [WORD_W-1:0]       rdata_q;
  logic                    rvalid_q;
  logic                    acc_ok;
  reg_sel_e                sel;
  logic                    wr_ctrl;
  logic                    rd_lo;
  logic [BANK_W-1:0]       bank_sel;
  logic [WORD_W-1:0]       rdata_d;

  assign acc_ok = req_i && (be_i == {BE_W{1'b1}}) && (addr_i[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (acc_ok) begin
      unique case (addr_i)
        OFS_CNT_LO: sel = SEL_LO;
        OFS_CNT_HI: sel = SEL_HI;
        OFS_CTRL:   sel = SEL_CTRL;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  assign wr_ctrl = we_i && (sel == SEL_CTRL);
  assign rd_lo   = !we_i && (sel == SEL_LO);

  // counter words only load while stopped
  assign ld_o[0] = we_i && (sel == SEL_LO) && !ctrl_q[RUN_BIT];
  assign ld_o[1] = we_i && (sel == SEL_HI) && !ctrl_q[RUN_BIT];

  assign ratio_chg_o = wr_ctrl &&
      (wdata_i[RATIO_LSB +: RATIO_W] != ctrl_q[RATIO_LSB +: RATIO_W]);

  for (genvar c = 0; c < NCORES; c++) begin : g_bank_we
    assign bank_we_o[c] = wr_ctrl && (core_i == CORE_W'(c));
  end
  assign bank_wdata_o = wdata_i[BANK_LSB +: BANK_W];

  always_comb begin
    bank_sel = '0;
    for (int c = 0; c < NCORES; c++) begin
      if (core_i == CORE_W'(c)) bank_sel = bank_ctrl_i[c*BANK_W +: BANK_W];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LO:   rdata_d = count_i[WORD_W-1:0];
      SEL_HI:   rdata_d = snap_q;
      SEL_CTRL: rdata_d = ctrl_q | (WORD_W'(bank_sel) << BANK_LSB);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      snap_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & ~BANK_MASK;
      if (rd_lo)   snap_q <= count_i[CNT_W-1:WORD_W];
      rvalid_q <= req_i && !we_i;
      rdata_q  <= (req_i && !we_i) ? rdata_d : '0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/shared_count64.sv
module shared_count64
  import shared_count64_pkg::*;
#(
  parameter  int unsigned NCORES = 4,
  localparam int unsigned CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [3:0]               be_i,
  input  logic [4:0]               addr_i,
  input  logic [31:0]              wdata_i,
  input  logic [CORE_W-1:0]        core_i,
  input  logic [NCORES*3-1:0]      bank_ctrl_i,
  output logic [31:0]              rdata_o,
  output logic                     rvalid_o,
  output logic [NCORES-1:0]        bank_we_o,
  output logic [2:0]               bank_wdata_o,
  output logic [63:0]              count_o,
  output logic                     enable_o
);
  logic [WORD_W-1:0] ctrl;
  logic [1:0]        cnt_ld;
  logic              ratio_chg;
  logic              tick;

  sc_regif #(
    .NCORES (NCORES),
    .CORE_W (CORE_W)
  ) u_regif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .be_i         (be_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .core_i       (core_i),
    .bank_ctrl_i  (bank_ctrl_i),
    .count_i      (count_o),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .ctrl_o       (ctrl),
    .ld_o         (cnt_ld),
    .ratio_chg_o  (ratio_chg),
    .bank_we_o    (bank_we_o),
    .bank_wdata_o (bank_wdata_o)
  );

  sc_prescaler #(
    .RATIO_W (RATIO_W)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl[RUN_BIT]),
    .ratio_i   (ctrl[RATIO_LSB +: RATIO_W]),
    .restart_i (ratio_chg),
    .tick_o    (tick)
  );

  sc_counter #(
    .WORD_W (WORD_W),
    .NWORDS (CNT_W / WORD_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .ld_i    (cnt_ld),
    .wdata_i (wdata_i),
    .count_o (count_o)
  );

  assign enable_o = ctrl[RUN_BIT];
endmodule

// File: rtl/shared_count64_chk.sv
module shared_count64_chk #(
  parameter int unsigned NCORES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [63:0]       count_i,
  input logic              enable_i,
  input logic [1:0]        ld_i,
  input logic              rvalid_i,
  input logic [NCORES-1:0] bank_we_i
);
  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && ld_i == 2'b00) |=> $stable(count_i));

  // R2
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> (count_i == $past(count_i) || count_i == $past(count_i) + 64'd1));

  // R5
  load_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i[0] |=> (count_i[31:0] == $past(wdata_i)));

  // R5
  load_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i[1] |=> (count_i[63:32] == $past(wdata_i)));

  // R10
  rvalid_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_i);

  // R10
  rvalid_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_i);

  // R6
  bank_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we_i));
endmodule

bind shared_count64 shared_count64_chk #(.NCORES(NCORES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .count_i   (count_o),
  .enable_i  (enable_o),
  .ld_i      (cnt_ld),
  .rvalid_i  (rvalid_o),
  .bank_we_i (bank_we_o)
);

// File: tb/shared_count64_test.sv
module shared_count64_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  be_s = 4'hF;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  core_s = '0;
  logic [11:0] bank_ctrl = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [3:0]  bank_we;
  logic [2:0]  bank_wdata;
  logic [63:0] count;
  logic        enable;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model
  logic [63:0] m_base = '0;
  int          m_ref = 0;
  int          m_p = 0;
  bit          m_en = 1'b0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_snap = '0;

  shared_count64 #(.NCORES(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be_s),
    .addr_i(addr), .wdata_i(wdata), .core_i(core_s), .bank_ctrl_i(bank_ctrl),
    .rdata_o(rdata), .rvalid_o(rvalid), .bank_we_o(bank_we),
    .bank_wdata_o(bank_wdata), .count_o(count), .enable_o(enable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_cnt(input int x);
    return m_en ? m_base + 64'((x - m_ref) / (m_p + 1)) : m_base;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rvalid", 64'(rvalid), 64'd0);
      end else begin
        chk(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus(input bit w, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic [1:0] core, input string tag);
    int x;
    bit ok;
    logic [31:0] e;
    logic [63:0] c1;
    logic [3:0] exp_we;
    @(negedge clk);
    x = cyc;
    req = 1'b1; we = w; addr = a; wdata = d; be_s = be; core_s = core;
    ok = (be == 4'hF) && (a[1:0] == 2'b00);
    if (!w) begin
      e = '0;
      if (ok) begin
        case (a)
          5'h00: begin e = model_cnt(x)[31:0]; m_snap = model_cnt(x)[63:32]; end
          5'h04: e = m_snap;
          5'h08: e = m_ctrl | {28'd0, bank_ctrl[core*3 +: 3], 1'b0};
          default: e = '0;
        endcase
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end else begin
      #1;
      exp_we = (ok && a == 5'h08) ? (4'b0001 << core) : 4'b0000;
      chk({tag, " bank_we"}, 64'(bank_we), 64'(exp_we));
      if (exp_we != 0) chk({tag, " bank_wdata"}, 64'(bank_wdata), 64'(d[3:1]));
      if (ok && (a == 5'h00 || a == 5'h04) && !m_en) begin
        if (a == 5'h00) m_base[31:0] = d; else m_base[63:32] = d;
      end
      if (ok && a == 5'h08) begin
        c1 = model_cnt(x + 1);
        if (d[0] && (!m_en || int'(d[15:8]) != m_p)) begin
          m_base = c1; m_ref = x + 1;
        end else if (!d[0]) begin
          m_base = c1;
        end
        m_en = d[0]; m_p = int'(d[15:8]); m_ctrl = d & ~32'h0000_000E;
      end
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic chk_cnt(input string tag);
    @(negedge clk);
    chk(tag, count, model_cnt(cyc));
    chk({tag, " enable_o"}, 64'(enable), 64'(m_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 64'd0);
    chk("R1 enable in reset", 64'(enable), 64'd0);
    rst_n = 1'b1;
    chk_cnt("R1 count after reset");
    bus(0, 5'h08, 0, 4'hF, 0, "R1 ctrl read");
    bus(0, 5'h00, 0, 4'hF, 0, "R1 lo read");
    bus(0, 5'h04, 0, 4'hF, 0, "R1 hi read");

    // R6 / R7 banked routing and merge
    bus(1, 5'h08, 32'h0000_300E, 4'hF, 2, "R6 ctrl write core2");
    bank_ctrl = 12'b000_000_101_000;
    bus(0, 5'h08, 0, 4'hF, 1, "R7 ctrl read core1");
    bus(0, 5'h08, 0, 4'hF, 3, "R7 ctrl read core3");
    bus(1, 5'h08, 32'h0000_0004, 4'hF, 0, "R6 ctrl write core0");
    bus(0, 5'h08, 0, 4'hF, 1, "R7 ctrl read after clear");

    // R5 load while stopped
    bus(1, 5'h00, 32'hFFFF_FFF0, 4'hF, 0, "R5 load lo");
    bus(1, 5'h04, 32'h0000_0001, 4'hF, 0, "R5 load hi");
    chk_cnt("R5 count after load");
    bus(0, 5'h00, 0, 4'hF, 0, "R4 lo read stopped");
    bus(0, 5'h04, 0, 4'hF, 0, "R4 hi read stopped");

    // R2 run at ratio 0, R4 snapshot across wrap
    bus(1, 5'h08, 32'h0000_0001, 4'hF, 0, "R2 enable p0");
    bus(0, 5'h00, 0, 4'hF, 0, "R4 lo read running");
    repeat (30) @(negedge clk);
    bus(0, 5'h04, 0, 4'hF, 0, "R4 hi read is snapshot");
    chk_cnt("R2 count after wrap");
    for (int i = 0; i < 6; i++) chk_cnt("R2 p0 step");

    // R5 ignored while running
    bus(1, 5'h00, 32'h0000_1234, 4'hF, 0, "R5 write while running");
    bus(0, 5'h00, 0, 4'hF, 0, "R5 lo unchanged by running write");
    bus(1, 5'h04, 32'hAAAA_0000, 4'hF, 0, "R5 hi write while running");
    chk_cnt("R5 hi unchanged by running write");

    // R8 ratio change while running
    bus(1, 5'h08, 32'h0000_0301, 4'hF, 0, "R8 ratio to 3");
    for (int i = 0; i < 14; i++) chk_cnt("R8 step after ratio change");
    bus(1, 5'h08, 32'h0000_0101, 4'hF, 0, "R8 ratio to 1");
    for (int i = 0; i < 9; i++) chk_cnt("R8 step after ratio change 1");

    // R3 stop
    bus(1, 5'h08, 32'h0000_0100, 4'hF, 0, "R3 disable");
    for (int i = 0; i < 12; i++) chk_cnt("R3 hold");
    bus(0, 5'h00, 0, 4'hF, 0, "R3 lo read stopped");

    // R2 max ratio
    bus(1, 5'h08, 32'h0000_FF00, 4'hF, 0, "R2 set p255");
    bus(1, 5'h08, 32'h0000_FF01, 4'hF, 0, "R2 enable p255");
    for (int i = 0; i < 530; i++) chk_cnt("R2 p255 step");
    bus(1, 5'h08, 32'h0000_0000, 4'hF, 0, "R3 disable again");
    chk_cnt("R3 stopped");

    // R9 rejected accesses
    bus(1, 5'h00, 32'hDEAD_BEEF, 4'h3, 0, "R9 partial write lo");
    bus(0, 5'h00, 0, 4'h7, 0, "R9 partial read lo");
    bus(1, 5'h10, 32'h0000_FFFF, 4'hF, 1, "R9 write outside regs");
    bus(0, 5'h10, 0, 4'hF, 0, "R9 read outside regs");
    bus(1, 5'h09, 32'h0000_00FF, 4'hF, 2, "R9 misaligned ctrl write");
    bus(1, 5'h08, 32'h0000_00FF, 4'h1, 3, "R9 partial ctrl write");
    bus(0, 5'h00, 0, 4'hF, 0, "R9 lo unchanged");
    bus(0, 5'h08, 0, 4'hF, 0, "R9 ctrl unchanged");
    chk_cnt("R9 count unchanged");

    repeat (3) @(negedge clk);
    chk("R10 all reads answered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule